// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits behind the bus interface of a byte-wide parallel flash and turns host write cycles into commands for the embedded program and erase engines. Every write arrives as a single-cycle strobe with its address and data already captured. The decoder follows the multi-cycle unlock handshakes. When a handshake completes, it raises a one-cycle go strobe and holds the captured target address and data for the engine.

The decoder also owns the identification read mode. While that mode is active, reads return the manufacturer code, the device code (which depends on the boot-block placement) or a sector's protect flag. The engines report back through three inputs: program running, erase running and erase suspended. These inputs decide which writes the decoder still honours. Timers, status polling bits and the cell array are outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_ni` is low and after it rises, the decoder is in read mode: `autosel_o` is 0, every go strobe is 0, and `cmd_addr_o`/`cmd_data_o` are 0.
- R2: A write of F0h at any address returns the decoder to read mode from any point of a sequence, including identification mode. The one exception is the data slot of a program command.
- R3: AAh at 555h, then 55h at AAAh, then A0h at 555h arms a program. The next write raises `prog_go_o` for exactly one cycle, in the cycle after that write, with that write's address on `cmd_addr_o` and its data on `cmd_data_o`. Only address bits 11:0 are compared for 555h and AAAh.
- R4: The unlock pair followed by 90h at 555h enters identification mode (`autosel_o`=1). In this mode, with address bits 1:0 = 00, a read gives 7Fh when bit 8 is 0 and 1Ch when bit 8 is 1. With bits 1:0 = 01, it gives 7Fh when bit 8 is 0, and when bit 8 is 1 it gives 92h (TOP_BOOT=1) or 97h (TOP_BOOT=0).
- R5: In identification mode, address bits 1:0 = 10 return 0000000b followed by the protect flag `sector_prot_i[addr_i[17:13]]` in bit 0. Bits 1:0 = 11 return 00h.
- R6: The unlock pair, then 80h at 555h, then a second AAh at 555h and 55h at AAAh, then 10h at 555h raises `chip_erase_go_o` for one cycle.
- R7: The same five-write erase prefix followed by 30h at any address raises `sector_erase_go_o` for one cycle. `cmd_addr_o` holds that address and `cmd_sector_o` holds its bits 17:13.
- R8: Any write whose address or data does not match the expected step ends the sequence in read mode and raises no strobe. A correct sequence that follows is then accepted from its first write. At most one go strobe is high in any cycle.
- R9: While `prog_busy_i` is high, every write is ignored, F0h included. Sequence progress and identification mode are kept unchanged.
- R10: While `erase_busy_i` is high and `erase_susp_i` is low, a write of B0h at any address raises `suspend_o` for one cycle. All other writes, including 30h, are ignored.
- R11: While `erase_susp_i` is high, a write of 30h at any address raises `resume_o` for one cycle. All other writes, including repeated B0h, are ignored.
- R12: Outside identification mode, `id_data_o` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | One-cycle write strobe |
| addr_i | input | 18 | Byte address for writes and identification reads |
| data_i | input | 8 | Write data |
| prog_busy_i | input | 1 | Program engine running |
| erase_busy_i | input | 1 | Erase engine running, not suspended |
| erase_susp_i | input | 1 | Erase engine suspended |
| sector_prot_i | input | 32 | Protect flag for each sector |
| prog_go_o | output | 1 | Program start strobe |
| chip_erase_go_o | output | 1 | Whole-array erase start strobe |
| sector_erase_go_o | output | 1 | Sector erase start strobe |
| suspend_o | output | 1 | Erase suspend strobe |
| resume_o | output | 1 | Erase resume strobe |
| cmd_addr_o | output | 18 | Captured target address |
| cmd_data_o | output | 8 | Captured target data |
| cmd_sector_o | output | 5 | Sector field of the captured address |
| autosel_o | output | 1 | Identification mode active |
| id_data_o | output | 8 | Identification read data |

## Verification
The assertions assume that `erase_busy_i` and `erase_susp_i` are never high together. They also assume that the engine status inputs change only between writes, so each write meets one well-defined busy condition. The stimulus raises at most one status input at a time and changes it only in idle cycles. Every write is a single-cycle strobe followed by at least one idle cycle, and identification reads only move `addr_i` while `wr_i` is low.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_AUTO,
    ST_PROG, ST_ERS0, ST_ERS1, ST_ERS2
  } fcd_state_e;

  localparam logic [7:0] D_UNL_A = 8'hAA;
  localparam logic [7:0] D_UNL_B = 8'h55;
  localparam logic [7:0] D_RESET = 8'hF0;
  localparam logic [7:0] D_PROG  = 8'hA0;
  localparam logic [7:0] D_AUTO  = 8'h90;
  localparam logic [7:0] D_ERS   = 8'h80;
  localparam logic [7:0] D_CHIP  = 8'h10;
  localparam logic [7:0] D_SECT  = 8'h30;
  localparam logic [7:0] D_SUSP  = 8'hB0;

  localparam logic [7:0] ID_MFR0 = 8'h7F;
  localparam logic [7:0] ID_MFR1 = 8'h1C;
  localparam logic [7:0] ID_TOP  = 8'h92;
  localparam logic [7:0] ID_BOT  = 8'h97;
endpackage

// File: rtl/fcd_match.sv
`timescale 1ns/1ps
module fcd_match
  import flash_cmd_pkg::*;
#(
  parameter int CMD_AW = 12
) (
  input  logic [CMD_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              unl_a_hit_o,
  output logic              unl_b_hit_o,
  output logic              cmd_at_o
);
  localparam logic [CMD_AW-1:0] A_CMD = CMD_AW'('h555);
  localparam logic [CMD_AW-1:0] A_ALT = CMD_AW'('hAAA);

  assign cmd_at_o    = (addr_i == A_CMD);
  assign unl_a_hit_o = cmd_at_o && (data_i == D_UNL_A);
  assign unl_b_hit_o = (addr_i == A_ALT) && (data_i == D_UNL_B);
endmodule

// File: rtl/fcd_fsm.sv
`timescale 1ns/1ps
module fcd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              prog_busy_i,
  input  logic              erase_busy_i,
  input  logic              erase_susp_i,
  input  logic              unl_a_hit_i,
  input  logic              unl_b_hit_i,
  input  logic              cmd_at_i,
  output logic              autosel_o,
  output logic              prog_go_o,
  output logic              chip_erase_go_o,
  output logic              sector_erase_go_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  fcd_state_e st_q, st_d;
  logic prog_d, chip_d, sect_d, susp_d, res_d, lat;

  always_comb begin
    st_d   = st_q;
    prog_d = 1'b0;
    chip_d = 1'b0;
    sect_d = 1'b0;
    susp_d = 1'b0;
    res_d  = 1'b0;
    lat    = 1'b0;
    if (wr_i && !prog_busy_i) begin
      if (erase_susp_i) begin
        res_d = (data_i == D_SECT);
      end else if (erase_busy_i) begin
        susp_d = (data_i == D_SUSP);
      end else begin
        st_d = ST_READ;  // default: any mismatch or F0h lands here
        unique case (st_q)
          ST_READ, ST_AUTO: if (unl_a_hit_i) st_d = ST_UNL1;
          ST_UNL1:          if (unl_b_hit_i) st_d = ST_UNL2;
          ST_UNL2: begin
            if (cmd_at_i) begin
              if (data_i == D_PROG)      st_d = ST_PROG;
              else if (data_i == D_AUTO) st_d = ST_AUTO;
              else if (data_i == D_ERS)  st_d = ST_ERS0;
            end
          end
          ST_PROG: begin
            prog_d = 1'b1;
            lat    = 1'b1;
          end
          ST_ERS0: if (unl_a_hit_i) st_d = ST_ERS1;
          ST_ERS1: if (unl_b_hit_i) st_d = ST_ERS2;
          ST_ERS2: begin
            if (cmd_at_i && data_i == D_CHIP) begin
              chip_d = 1'b1;
            end else if (data_i == D_SECT) begin
              sect_d = 1'b1;
              lat    = 1'b1;
            end
          end
          default: st_d = ST_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q              <= ST_READ;
      prog_go_o         <= 1'b0;
      chip_erase_go_o   <= 1'b0;
      sector_erase_go_o <= 1'b0;
      suspend_o         <= 1'b0;
      resume_o          <= 1'b0;
      cmd_addr_o        <= '0;
      cmd_data_o        <= '0;
    end else begin
      st_q              <= st_d;
      prog_go_o         <= prog_d;
      chip_erase_go_o   <= chip_d;
      sector_erase_go_o <= sect_d;
      suspend_o         <= susp_d;
      resume_o          <= res_d;
      if (lat) begin
        cmd_addr_o <= addr_i;
        cmd_data_o <= data_i;
      end
    end
  end

  assign autosel_o = (st_q == ST_AUTO);

  // R3
  prog_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_go_o |-> $past(wr_i) && !$past(prog_busy_i) && cmd_data_o == $past(data_i)
                  && cmd_addr_o == $past(addr_i));
  // R7
  sect_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_erase_go_o |-> $past(wr_i) && $past(data_i) == D_SECT && cmd_addr_o == $past(addr_i));
  // R8
  one_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_go_o, chip_erase_go_o, sector_erase_go_o, suspend_o, resume_o}));
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && prog_busy_i) |=> $stable(st_q) && !prog_go_o && !chip_erase_go_o
                              && !sector_erase_go_o && !suspend_o && !resume_o);
  // R10
  susp_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> $past(erase_busy_i) && !$past(erase_susp_i) && $past(data_i) == D_SUSP);
  // R11
  res_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> $past(erase_susp_i) && $past(wr_i) && $past(data_i) == D_SECT);
endmodule

// File: rtl/fcd_id.sv
`timescale 1ns/1ps
module fcd_id
  import flash_cmd_pkg::*;
#(
  parameter int SECT_W   = 5,
  parameter bit TOP_BOOT = 1'b1,
  localparam int NSECT   = 1 << SECT_W
) (
  input  logic              autosel_i,
  input  logic              bank_i,
  input  logic [1:0]        off_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic [NSECT-1:0]  prot_i,
  output logic [DATA_W-1:0] id_o
);
  logic [DATA_W-1:0] dev_code;

  if (TOP_BOOT) begin : g_top
    assign dev_code = ID_TOP;
  end else begin : g_bot
    assign dev_code = ID_BOT;
  end

  always_comb begin
    id_o = '0;
    if (autosel_i) begin
      unique case (off_i)
        2'b00: id_o = bank_i ? ID_MFR1 : ID_MFR0;
        2'b01: id_o = bank_i ? dev_code : ID_MFR0;
        2'b10: id_o = {{(DATA_W-1){1'b0}}, prot_i[sect_i]};
        default: id_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int SECT_LSB = 13,
  parameter int CMD_AW   = 12,
  parameter bit TOP_BOOT = 1'b1,
  localparam int SECT_W  = ADDR_W - SECT_LSB,
  localparam int NSECT   = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              prog_busy_i,
  input  logic              erase_busy_i,
  input  logic              erase_susp_i,
  input  logic [NSECT-1:0]  sector_prot_i,
  output logic              prog_go_o,
  output logic              chip_erase_go_o,
  output logic              sector_erase_go_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic [SECT_W-1:0] cmd_sector_o,
  output logic              autosel_o,
  output logic [DATA_W-1:0] id_data_o
);
  logic unl_a_hit, unl_b_hit, cmd_at;

  fcd_match #(.CMD_AW(CMD_AW)) u_match (
    .addr_i      (addr_i[CMD_AW-1:0]),
    .data_i      (data_i),
    .unl_a_hit_o (unl_a_hit),
    .unl_b_hit_o (unl_b_hit),
    .cmd_at_o    (cmd_at)
  );

  fcd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .wr_i              (wr_i),
    .addr_i            (addr_i),
    .data_i            (data_i),
    .prog_busy_i       (prog_busy_i),
    .erase_busy_i      (erase_busy_i),
    .erase_susp_i      (erase_susp_i),
    .unl_a_hit_i       (unl_a_hit),
    .unl_b_hit_i       (unl_b_hit),
    .cmd_at_i          (cmd_at),
    .autosel_o         (autosel_o),
    .prog_go_o         (prog_go_o),
    .chip_erase_go_o   (chip_erase_go_o),
    .sector_erase_go_o (sector_erase_go_o),
    .suspend_o         (suspend_o),
    .resume_o          (resume_o),
    .cmd_addr_o        (cmd_addr_o),
    .cmd_data_o        (cmd_data_o)
  );

  fcd_id #(.SECT_W(SECT_W), .TOP_BOOT(TOP_BOOT)) u_id (
    .autosel_i (autosel_o),
    .bank_i    (addr_i[8]),
    .off_i     (addr_i[1:0]),
    .sect_i    (addr_i[ADDR_W-1:SECT_LSB]),
    .prot_i    (sector_prot_i),
    .id_o      (id_data_o)
  );

  assign cmd_sector_o = cmd_addr_o[ADDR_W-1:SECT_LSB];
endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [17:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        prog_busy_i = 1'b0, erase_busy_i = 1'b0, erase_susp_i = 1'b0;
  logic [31:0] sector_prot_i = 32'h0000_0A05;
  logic        prog_go_o, chip_erase_go_o, sector_erase_go_o, suspend_o, resume_o, autosel_o;
  logic [17:0] cmd_addr_o;
  logic [7:0]  cmd_data_o, id_data_o;
  logic [4:0]  cmd_sector_o;

  flash_cmd_decoder uut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model: 0 read,1 unl1,2 unl2,3 ident,4 prog,5..7 erase prefix
  int ms;
  logic e_prog, e_chip, e_sect, e_susp, e_res;
  logic [17:0] e_addr;
  logic [7:0]  e_data;

  always @(posedge clk_i or negedge rst_ni) begin
    int nms;
    if (!rst_ni) begin
      ms <= 0; e_prog <= 0; e_chip <= 0; e_sect <= 0; e_susp <= 0; e_res <= 0;
      e_addr <= '0; e_data <= '0;
    end else begin
      e_prog <= 0; e_chip <= 0; e_sect <= 0; e_susp <= 0; e_res <= 0;
      if (wr_i && !prog_busy_i) begin
        if (erase_susp_i) e_res <= (data_i == 8'h30);
        else if (erase_busy_i) e_susp <= (data_i == 8'hB0);
        else begin
          nms = 0;
          case (ms)
            0, 3: if (addr_i[11:0] == 12'h555 && data_i == 8'hAA) nms = 1;
            1: if (addr_i[11:0] == 12'hAAA && data_i == 8'h55) nms = 2;
            2: if (addr_i[11:0] == 12'h555)
                 nms = (data_i == 8'hA0) ? 4 : (data_i == 8'h90) ? 3 : (data_i == 8'h80) ? 5 : 0;
            4: begin e_prog <= 1; e_addr <= addr_i; e_data <= data_i; end
            5: if (addr_i[11:0] == 12'h555 && data_i == 8'hAA) nms = 6;
            6: if (addr_i[11:0] == 12'hAAA && data_i == 8'h55) nms = 7;
            7: if (addr_i[11:0] == 12'h555 && data_i == 8'h10) e_chip <= 1;
               else if (data_i == 8'h30) begin e_sect <= 1; e_addr <= addr_i; e_data <= data_i; end
            default: ;
          endcase
          ms <= nms;
        end
      end
    end
  end

  function automatic logic [7:0] exp_id(int m, logic [17:0] a);
    if (m != 3) return 8'h00;
    case (a[1:0])
      2'b00: return a[8] ? 8'h1C : 8'h7F;
      2'b01: return a[8] ? 8'h92 : 8'h7F;
      2'b10: return {7'b0, sector_prot_i[a[17:13]]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (!done) begin
      chk(cur_req, "prog_go", prog_go_o, e_prog);
      chk(cur_req, "chip_go", chip_erase_go_o, e_chip);
      chk(cur_req, "sect_go", sector_erase_go_o, e_sect);
      chk(cur_req, "suspend", suspend_o, e_susp);
      chk(cur_req, "resume", resume_o, e_res);
      chk(cur_req, "cmd_addr", cmd_addr_o, e_addr);
      chk(cur_req, "cmd_data", cmd_data_o, e_data);
      chk(cur_req, "cmd_sector", cmd_sector_o, e_addr[17:13]);
      chk(cur_req, "autosel", autosel_o, ms == 3);
      chk(cur_req, "id_data", id_data_o, exp_id(ms, addr_i));
    end
  end

  task automatic wr(logic [17:0] a, logic [7:0] d);
    @(posedge clk_i); #2;
    wr_i = 1'b1; addr_i = a; data_i = d;
    @(posedge clk_i); #2;
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [17:0] a);
    @(posedge clk_i); #2;
    addr_i = a;
    @(negedge clk_i);
  endtask

  task automatic unlock();
    wr(18'h00555, 8'hAA);
    wr(18'h00AAA, 8'h55);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "autosel_after_reset", autosel_o, 0);

    // R4: identification codes
    cur_req = "R4";
    unlock(); wr(18'h00555, 8'h90);
    rd(18'h00000); chk("R4", "mfr0", id_data_o, 8'h7F);
    rd(18'h00100); chk("R4", "mfr1", id_data_o, 8'h1C);
    rd(18'h00001); chk("R4", "dev0", id_data_o, 8'h7F);
    rd(18'h00101); chk("R4", "dev1", id_data_o, 8'h92);
    // R5: protect verify
    cur_req = "R5";
    rd(18'h00002); chk("R5", "prot_s0", id_data_o, 8'h01);
    rd(18'h02002); chk("R5", "prot_s1", id_data_o, 8'h00);
    rd(18'h06002); chk("R5", "prot_s3", id_data_o, 8'h00);
    rd(18'h16002); chk("R5", "prot_s11", id_data_o, 8'h01);
    rd(18'h00003); chk("R5", "off3", id_data_o, 8'h00);
    // R2: F0h leaves identification
    cur_req = "R2";
    wr(18'h01234, 8'hF0);
    rd(18'h00000); chk("R2", "autosel_exit", autosel_o, 0);
    // R12: no id data in read mode
    chk("R12", "id_in_read", id_data_o, 8'h00);
    cur_req = "R2";
    unlock(); wr(18'h3FFFF, 8'hF0); wr(18'h00555, 8'hA0);
    @(negedge clk_i); chk("R2", "no_prog_after_reset", prog_go_o, 0);

    // R3: program
    cur_req = "R3";
    unlock(); wr(18'h00555, 8'hA0); wr(18'h2ABCD, 8'h5A);
    @(negedge clk_i);
    chk("R3", "prog_go", prog_go_o, 1);
    chk("R3", "prog_addr", cmd_addr_o, 18'h2ABCD);
    chk("R3", "prog_data", cmd_data_o, 8'h5A);
    unlock(); wr(18'h00555, 8'hA0); wr(18'h00010, 8'hF0);  // F0h is program data here
    @(negedge clk_i); chk("R3", "prog_f0_data", cmd_data_o, 8'hF0);

    // R6: chip erase
    cur_req = "R6";
    unlock(); wr(18'h00555, 8'h80); unlock(); wr(18'h00555, 8'h10);
    @(negedge clk_i); chk("R6", "chip_go", chip_erase_go_o, 1);

    // R7: sector erase
    cur_req = "R7";
    unlock(); wr(18'h00555, 8'h80); unlock(); wr(18'h3C123, 8'h30);
    @(negedge clk_i);
    chk("R7", "sect_go", sector_erase_go_o, 1);
    chk("R7", "sect_num", cmd_sector_o, 5'h1E);

    // R8: mismatches
    cur_req = "R8";
    wr(18'h00555, 8'hAA); wr(18'h00AAA, 8'h54); wr(18'h00555, 8'hA0); wr(18'h00001, 8'h11);
    @(negedge clk_i); chk("R8", "bad_data", prog_go_o, 0);
    wr(18'h00556, 8'hAA); wr(18'h00AAA, 8'h55); wr(18'h00555, 8'h90);
    @(negedge clk_i); chk("R8", "bad_addr", autosel_o, 0);
    unlock(); wr(18'h00555, 8'h80); wr(18'h00555, 8'hAA); wr(18'h00AAB, 8'h55); wr(18'h00555, 8'h10);
    @(negedge clk_i); chk("R8", "bad_second_unlock", chip_erase_go_o, 0);
    unlock(); wr(18'h00555, 8'h80); unlock(); wr(18'h00554, 8'h10);
    @(negedge clk_i); chk("R8", "bad_chip_addr", chip_erase_go_o, 0);
    unlock(); wr(18'h00555, 8'h90);
    @(negedge clk_i); chk("R8", "recover", autosel_o, 1);
    wr(18'h00000, 8'hF0);

    // R9: program busy ignores writes
    cur_req = "R9";
    wr(18'h00555, 8'hAA);
    @(posedge clk_i); #2 prog_busy_i = 1'b1;
    wr(18'h00000, 8'hF0); wr(18'h00123, 8'h77); wr(18'h00555, 8'hAA);
    @(posedge clk_i); #2 prog_busy_i = 1'b0;
    wr(18'h00AAA, 8'h55); wr(18'h00555, 8'h90);
    @(negedge clk_i); chk("R9", "progress_kept", autosel_o, 1);
    @(posedge clk_i); #2 prog_busy_i = 1'b1;
    wr(18'h00000, 8'hF0);
    @(negedge clk_i); chk("R9", "autosel_kept", autosel_o, 1);
    @(posedge clk_i); #2 prog_busy_i = 1'b0;
    wr(18'h00000, 8'hF0);

    // R10: erase running
    cur_req = "R10";
    @(posedge clk_i); #2 erase_busy_i = 1'b1;
    wr(18'h08000, 8'h30);
    @(negedge clk_i); chk("R10", "extra_30", sector_erase_go_o | resume_o, 0);
    wr(18'h00555, 8'hAA); wr(18'h11111, 8'hB0);
    @(negedge clk_i); chk("R10", "suspend", suspend_o, 1);
    @(posedge clk_i); #2 erase_busy_i = 1'b0; erase_susp_i = 1'b1;

    // R11: erase suspended
    cur_req = "R11";
    wr(18'h00000, 8'hB0);
    @(negedge clk_i); chk("R11", "repeat_b0", suspend_o, 0);
    unlock(); wr(18'h00555, 8'h90);
    @(negedge clk_i); chk("R11", "no_autosel", autosel_o, 0);
    wr(18'h2F00F, 8'h30);
    @(negedge clk_i); chk("R11", "resume", resume_o, 1);
    @(posedge clk_i); #2 erase_susp_i = 1'b0; erase_busy_i = 1'b1;
    wr(18'h00000, 8'h30);
    @(negedge clk_i); chk("R10", "repeat_resume", resume_o, 0);
    wr(18'h00000, 8'hB0);
    @(negedge clk_i); chk("R10", "second_suspend", suspend_o, 1);
    @(posedge clk_i); #2 erase_busy_i = 1'b0;

    // R1: mid-sequence reset
    cur_req = "R1";
    unlock(); wr(18'h00555, 8'h90);
    @(posedge clk_i); #2 rst_ni = 1'b0;
    @(negedge clk_i); chk("R1", "async_clear", autosel_o, 0);
    @(posedge clk_i); #2 rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule